// File: doc/BRIEF.md
# Interrupt Vector Sequencer

This block picks the program-counter target of a small microcontroller whose program addresses are 12 bits wide, covering 4096 words. It acts when the core leaves reset and when an interrupt is taken. Six interrupt sources feed it, in priority order:

- external pin 0
- external pin 1
- timer 0 overflow
- timer 1 overflow
- time base tick
- real-time clock

Each source raises a one-cycle request pulse. The block keeps a pending flag for each source. It also takes a per-source enable, a global enable and a return-stack-full flag.

A source is taken only when all of these hold: it is pending, it is enabled, the global enable is set, and the stack has room. A request that cannot be taken yet stays pending. When the block takes a vector, it does four things in one cycle:

- raises a take strobe with the vector address
- acknowledges the winning source, which clears its pending flag
- asks the core to clear its global enable
- follows with exactly one stall cycle, standing for the dummy fetch that every control transfer costs

The reset vector at 000H is issued once after reset is released. The source vectors sit four words apart above it.

Top module: `intVecSeq`

## Requirements
- R1: In the first cycle after the first rising clock edge that follows reset release, vecTake is 1, vecAddr is 000H, srcAck is 0 and gieClr is 0. While rstN is low, vecTake, stall and srcAck are all 0.
- R2: Source i (bit i of reqIn, srcEn and srcAck, with 0 = external 0, 1 = external 1, 2 = timer 0, 3 = timer 1, 4 = time base, 5 = real-time clock) is vectored to address 4*(i+1): 004H, 008H, 00CH, 010H, 014H and 018H. Only srcAck bit i is asserted with it.
- R3: A source is taken only if it is pending, its srcEn bit is 1, globalEn is 1 and stackFull is 0.
- R4: A request blocked by a clear enable, a clear global enable or a full stack stays pending. It is taken once the block condition lifts, with no new pulse.
- R5: Every cycle with vecTake high is followed by exactly one cycle with stall high and vecTake low. No new take can come in the cycle after that stall.
- R6: When several eligible sources are pending, the one with the lowest bit index (lowest vector address) is taken first.
- R7: A source take raises gieClr and the acknowledge of the winner only. The other pending sources stay pending and are taken in later takes.
- R8: Asserting rstN low clears every pending flag. A request pending before reset is not taken after it.
- R9: When the block is idle and the request is eligible, a reqIn pulse sampled at clock edge e produces vecTake in the cycle after edge e+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| reqIn | input | 6 | One-cycle request pulses, one bit per source |
| srcEn | input | 6 | Per-source interrupt enables |
| globalEn | input | 1 | Global interrupt enable from the core |
| stackFull | input | 1 | Return stack has no free entry |
| vecTake | output | 1 | Load the program counter with vecAddr this cycle |
| vecAddr | output | 12 | Vector address, valid while vecTake is high |
| srcAck | output | 6 | One-hot acknowledge of the taken source |
| gieClr | output | 1 | Request to clear the global enable |
| stall | output | 1 | Dummy fetch cycle after a take |

## Verification
A corrupted pending flag shows up at the ports as one of two faults. A lost flag means a take that never happens. A stuck flag means a repeated take of the same vector. Either appears within two cycles of the source becoming eligible. A wrong latched winner index shows at once in vecAddr and srcAck during the take cycle, and a broken priority encoder shows the same way. A sequencing error shows in the cycle right after the take, as a missing or doubled stall.

// File: rtl/isvPkg.sv
package isvPkg;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadBoot;
    logic loadSrc;
    logic take;
    logic stall;
  } isvStrobes_t;

  typedef enum logic [1:0] {
    S_BOOT  = 2'd0,
    S_IDLE  = 2'd1,
    S_TAKE  = 2'd2,
    S_STALL = 2'd3
  } isvState_e;

endpackage

// File: rtl/isvControl.sv
module isvControl
  import isvPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyElig,
  output isvStrobes_t strobes
);

  isvState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      S_BOOT:  stateD = S_TAKE;
      S_IDLE:  stateD = anyElig ? S_TAKE : S_IDLE;
      S_TAKE:  stateD = S_STALL;
      S_STALL: stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= S_BOOT;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobes.loadBoot = (stateQ == S_BOOT);
    strobes.loadSrc  = (stateQ == S_IDLE) && anyElig;
    strobes.take     = (stateQ == S_TAKE);
    strobes.stall    = (stateQ == S_STALL);
  end

  AST_TAKE_THEN_STALL: assert property (@(posedge clk) disable iff (!rstN)
    strobes.take |=> (strobes.stall && !strobes.take)); // R5
  AST_STALL_THEN_GAP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stall |=> !strobes.take); // R5

endmodule

// File: rtl/isvDatapath.sv
module isvDatapath
  import isvPkg::*;
#(
  parameter int NUM_SRC      = 6,
  parameter int ADDR_W       = 12,
  parameter int SPACING_LOG2 = 2,
  parameter int IDX_W        = 3
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic               globalEn,
  input  logic               stackFull,
  input  isvStrobes_t        strobes,
  output logic               anyElig,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic [NUM_SRC-1:0] srcAck,
  output logic               gieClr
);

  logic [NUM_SRC-1:0] pendQ;
  logic [NUM_SRC-1:0] elig;
  logic [IDX_W-1:0]   winIdx;
  logic [IDX_W-1:0]   selIdxQ;

  // pending flags: set by pulse, cleared by own acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= (pendQ & ~srcAck) | reqIn;
  end

  assign elig    = (globalEn && !stackFull) ? (pendQ & srcEn) : '0;
  assign anyElig = |elig;

  // fixed priority: lowest index wins (scan from top, last hit stays)
  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i]) winIdx = IDX_W'(i + 1);
    end
  end

  // selected vector number: 0 = reset, i+1 = source i
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 selIdxQ <= '0;
    else if (strobes.loadBoot) selIdxQ <= '0;
    else if (strobes.loadSrc)  selIdxQ <= winIdx;
  end

  assign vecAddr = ADDR_W'(selIdxQ) << SPACING_LOG2;
  assign gieClr  = strobes.take && (selIdxQ != '0);

  for (genvar g = 0; g < NUM_SRC; g++) begin : gAck
    assign srcAck[g] = strobes.take && (selIdxQ == IDX_W'(g + 1));
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(srcAck)); // R7
  AST_ACK_WAS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (|srcAck) |-> (|(srcAck & pendQ))); // R4
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (|srcAck) |-> (($past(elig) & (srcAck - 1'b1)) == '0)); // R6
  AST_NO_ACK_IN_STALL: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stall |-> (srcAck == '0 && !gieClr)); // R5

endmodule

// File: rtl/intVecSeq.sv
module intVecSeq
  import isvPkg::*;
#(
  parameter int NUM_SRC      = 6,
  parameter int ADDR_W       = 12,
  parameter int SPACING_LOG2 = 2
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic               globalEn,
  input  logic               stackFull,
  output logic               vecTake,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic [NUM_SRC-1:0] srcAck,
  output logic               gieClr,
  output logic               stall
);

  localparam int IDX_W = $clog2(NUM_SRC + 1);

  isvStrobes_t strobes;
  logic        anyElig;

  isvControl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .anyElig (anyElig),
    .strobes (strobes)
  );

  isvDatapath #(
    .NUM_SRC      (NUM_SRC),
    .ADDR_W       (ADDR_W),
    .SPACING_LOG2 (SPACING_LOG2),
    .IDX_W        (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .reqIn     (reqIn),
    .srcEn     (srcEn),
    .globalEn  (globalEn),
    .stackFull (stackFull),
    .strobes   (strobes),
    .anyElig   (anyElig),
    .vecAddr   (vecAddr),
    .srcAck    (srcAck),
    .gieClr    (gieClr)
  );

  assign vecTake = strobes.take;
  assign stall   = strobes.stall;

  AST_TAKE_ONLY_WHEN_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    (vecTake && |srcAck) |-> $past(!stackFull && globalEn)); // R3
  AST_TAKE_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (vecTake && |srcAck) |-> (|($past(srcEn) & srcAck))); // R3
  AST_ACK_WITH_GIE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (|srcAck) |-> (gieClr && vecTake)); // R7

endmodule

// File: tb/intVecSeq_tb.sv
`timescale 1ns/1ps
module intVecSeq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  reqIn = '0;
  logic [5:0]  srcEn = '0;
  logic        globalEn = 1'b0;
  logic        stackFull = 1'b0;
  logic        vecTake;
  logic [11:0] vecAddr;
  logic [5:0]  srcAck;
  logic        gieClr;
  logic        stall;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  always #4 clk = ~clk;

  intVecSeq u_dut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .srcEn(srcEn),
    .globalEn(globalEn), .stackFull(stackFull), .vecTake(vecTake),
    .vecAddr(vecAddr), .srcAck(srcAck), .gieClr(gieClr), .stall(stall)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    testCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // one-cycle request pulse, sampled at the edge between the two negedges
  task automatic pulseReq(input logic [5:0] bits);
    @(negedge clk); reqIn = bits;
    @(negedge clk); reqIn = '0;
  endtask

  // call at a negedge in a take cycle: checks the take, then the stall cycle
  task automatic expectTake(input string tag, input logic [11:0] addr,
                            input logic [5:0] ack);
    check(tag, "vecTake", 32'(vecTake), 32'd1);
    check(tag, "vecAddr", 32'(vecAddr), 32'(addr));
    check(tag, "srcAck", 32'(srcAck), 32'(ack));
    check(tag, "gieClr", 32'(gieClr), 32'(ack != 0));
    @(negedge clk);
    check("R5", "stall", 32'(stall), 32'd1);
    check("R5", "vecTake in stall", 32'(vecTake), 32'd0);
  endtask

  task automatic expectQuiet(input string tag, input int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      check(tag, "no take", 32'(vecTake), 32'd0);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check("R1", "vecTake in reset", 32'(vecTake), 32'd0);
    check("R1", "stall in reset", 32'(stall), 32'd0);
    check("R1", "srcAck in reset", 32'(srcAck), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    expectTake("R1", 12'h000, 6'd0);
    @(negedge clk);
    check("R5", "idle after stall", 32'(vecTake | stall), 32'd0);
  endtask

  task automatic testEachSource();
    srcEn = 6'h3F; globalEn = 1'b1; stackFull = 1'b0;
    for (int i = 0; i < 6; i++) begin
      pulseReq(6'(1 << i));
      @(negedge clk);   // R9: take in the cycle after edge e+1
      expectTake("R2", 12'(4 * (i + 1)), 6'(1 << i));
      @(negedge clk);
      check("R5", "idle gap", 32'(vecTake), 32'd0);
    end
  endtask

  task automatic testBlocked();
    srcEn = 6'h3F & ~6'h04; globalEn = 1'b1;
    pulseReq(6'h04);
    expectQuiet("R3", 4);
    srcEn = 6'h3F;          // set at a negedge, picked up at next edge
    @(negedge clk);
    expectTake("R4", 12'h00C, 6'h04);
    @(negedge clk);
    stackFull = 1'b1;
    pulseReq(6'h01);
    expectQuiet("R3", 4);
    stackFull = 1'b0;
    @(negedge clk);
    expectTake("R4", 12'h004, 6'h01);
    @(negedge clk);
    globalEn = 1'b0;
    pulseReq(6'h20);
    expectQuiet("R3", 3);
    globalEn = 1'b1;
    @(negedge clk);
    expectTake("R4", 12'h018, 6'h20);
    @(negedge clk);
  endtask

  task automatic testPriority();
    srcEn = 6'h3F; globalEn = 1'b1; stackFull = 1'b0;
    pulseReq(6'h34);
    @(negedge clk);
    expectTake("R6", 12'h00C, 6'h04);
    @(negedge clk);
    check("R5", "gap before next", 32'(vecTake), 32'd0);
    @(negedge clk);
    expectTake("R7", 12'h014, 6'h10);
    @(negedge clk);
    @(negedge clk);
    expectTake("R7", 12'h018, 6'h20);
    expectQuiet("R7", 3);
  endtask

  task automatic testResetClears();
    stackFull = 1'b1;
    pulseReq(6'h02);
    expectQuiet("R8", 2);
    doReset();
    stackFull = 1'b0;
    expectQuiet("R8", 5);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    doReset();
    testEachSource();
    testBlocked();
    testPriority();
    testResetClears();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule